// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block takes one block-transfer request (a base address, a 16-bit register list and three control bits) and plays it out as a series of single-word memory accesses. The bit `pre_i` chooses whether the address is stepped before or after each access. The bit `up_i` chooses whether the transfer climbs or descends from the base. The bit `load_i` marks the accesses as loads or stores. Each access presents a word address, the register index it belongs to and the load/store direction, and it is held under a valid strobe until memory signals ready.

In every mode the lowest-numbered register in the list goes to the lowest address. A descending transfer therefore starts at the bottom of the block it covers and walks upward. The register nearest the base is then the highest-numbered one. When the sequence ends the block pulses `done_o` for one cycle and presents the base address moved by four bytes per listed register, which the caller may use for base write-back.

The controller has three named states. `ST_IDLE` waits for `start_i`. `ST_ISSUE` presents accesses. `ST_FINISH` raises done for one cycle. The transitions are:

- idle→issue, on a start with a non-empty list.
- idle→finish, on a start with an empty list.
- issue→issue, while registers remain or memory stalls.
- issue→finish, when the last access is accepted.
- finish→idle, unconditionally.

Top module: `mrt_seq`

## Requirements
- R1: After reset `busy_o`, `acc_valid_o` and `done_o` are all 0.
- R2: With `pre_i`=0 and `up_i`=1 (increment-after), the k-th access (k from 0) goes to base+4k.
- R3: With `pre_i`=1 and `up_i`=1 (increment-before), the k-th access goes to base+4+4k.
- R4: With `pre_i`=0 and `up_i`=0 (decrement-after), the highest listed register is accessed at base and the others sit below it 4 bytes apart. The k-th access therefore goes to base−4(n−1)+4k, where n is the number of set bits.
- R5: With `pre_i`=1 and `up_i`=0 (decrement-before), the highest listed register is accessed at base−4, so the k-th access goes to base−4n+4k.
- R6: Accesses are issued in ascending register index. `acc_reg_o` is the index of the k-th set bit of the list, where bit i stands for register i, and the addresses ascend in step with it.
- R7: During every access `acc_load_o` equals the `load_i` value captured at start (1 = load from memory, 0 = store to memory).
- R8: An access is accepted only on a clock edge where both `acc_valid_o` and `mem_ready_i` are 1. While `mem_ready_i` is 0 the address and register index are held.
- R9: Exactly n accesses are issued, and `done_o` is 1 for exactly one cycle: the cycle after the edge that accepts the last access.
- R10: A start with an all-zero register list issues no access, and `done_o` rises in the cycle after the start edge.
- R11: While `done_o` is 1, `wb_addr_o` equals base+4n when `up_i` was 1 and base−4n when `up_i` was 0, both modulo 2^32.
- R12: `start_i` is ignored while `busy_o` is 1, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transfer when idle |
| base_i | input | 32 | Base word address |
| reg_list_i | input | 16 | Register list, bit i = register i |
| pre_i | input | 1 | 1 = step address before access |
| up_i | input | 1 | 1 = ascending from base, 0 = descending |
| load_i | input | 1 | 1 = load, 0 = store |
| mem_ready_i | input | 1 | Memory accepts the presented access |
| busy_o | output | 1 | Transfer in progress |
| acc_valid_o | output | 1 | An access is presented |
| acc_addr_o | output | 32 | Word address of the access |
| acc_reg_o | output | 4 | Register index of the access |
| acc_load_o | output | 1 | Direction of the access |
| done_o | output | 1 | One-cycle completion pulse |
| wb_addr_o | output | 32 | Write-back address, valid with done |

## Verification
Every one of the four pre/up combinations is driven with sparse and dense lists, and a full 16-register list is included. A mix of single-bit, end-bit and scattered lists separates a start-address fault from a stepping fault and from an ordering fault. Stalling memory with a toggling ready shows whether accesses advance without acceptance. Descending runs that cross address zero and ascending runs that cross the top of the address space expose errors in wrap-around arithmetic. A start pulse during a run, an empty list and a single register check that requests are ignored while busy, that the empty case completes at once, and that done timing is right at the boundaries.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } mrt_state_e;

    typedef struct packed {
        logic pre;
        logic up;
        logic load;
    } mrt_ctrl_t;
endpackage

// File: rtl/mrt_popcount.sv
module mrt_popcount #(
    parameter int NREG  = 16,
    parameter int CNT_W = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0]  bits_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] partial [NREG+1];

    assign partial[0] = '0;
    for (genvar g = 0; g < NREG; g++) begin : g_sum
        assign partial[g+1] = partial[g] + CNT_W'(bits_i[g]);
    end
    assign count_o = partial[NREG];
endmodule

// File: rtl/mrt_addr_plan.sv
module mrt_addr_plan #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              pre_i,
    input  logic              up_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_edge;

    assign span     = ADDR_W'(count_i) * STEP;
    assign low_edge = base_i - span;

    always_comb begin
        unique case ({pre_i, up_i})
            2'b01:   first_o = base_i;
            2'b11:   first_o = base_i + STEP;
            2'b00:   first_o = low_edge + STEP;
            default: first_o = low_edge;
        endcase
        wb_o = up_i ? (base_i + span) : low_edge;
    end
endmodule

// File: rtl/mrt_pick.sv
module mrt_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [NREG-1:0]  rest_o
);
    logic [NREG-1:0] lowest;

    assign lowest = mask_i & (~mask_i + NREG'(1));
    assign rest_o = mask_i & ~lowest;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (lowest[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   reg_list_i,
    input  logic              pre_i,
    input  logic              up_i,
    input  logic              load_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic              acc_valid_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [IDX_W-1:0]  acc_reg_o,
    output logic              acc_load_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] wb_addr_o
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    mrt_state_e        state_q, state_d;
    mrt_ctrl_t         ctrl_q;
    logic [NREG-1:0]   remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_q;

    logic [CNT_W-1:0]  req_count;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_wb;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_rest;
    logic              accept;

    mrt_popcount #(.NREG(NREG), .CNT_W(CNT_W)) u_count (
        .bits_i  (reg_list_i),
        .count_o (req_count)
    );

    mrt_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i  (base_i),
        .count_i (req_count),
        .pre_i   (pre_i),
        .up_i    (up_i),
        .first_o (plan_first),
        .wb_o    (plan_wb)
    );

    mrt_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .mask_i (remain_q),
        .idx_o  (pick_idx),
        .rest_o (pick_rest)
    );

    assign accept = (state_q == ST_ISSUE) && mem_ready_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = (reg_list_i == '0) ? ST_FINISH : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mem_ready_i && (pick_rest == '0)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            remain_q <= '0;
            addr_q   <= '0;
            wb_q     <= '0;
        end else if ((state_q == ST_IDLE) && start_i) begin
            ctrl_q   <= '{pre: pre_i, up: up_i, load: load_i};
            remain_q <= reg_list_i;
            addr_q   <= plan_first;
            wb_q     <= plan_wb;
        end else if (accept) begin
            remain_q <= pick_rest;
            addr_q   <= addr_q + STEP;
        end
    end

    // outputs
    always_comb begin
        busy_o      = 1'b0;
        acc_valid_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  begin busy_o = 1'b1; acc_valid_o = 1'b1; end
            ST_FINISH: begin busy_o = 1'b1; done_o = 1'b1; end
            default:   ;
        endcase
        acc_addr_o = addr_q;
        acc_reg_o  = pick_idx;
        acc_load_o = ctrl_q.load;
        wb_addr_o  = wb_q;
    end
endmodule

// File: rtl/mrt_seq_chk.sv
module mrt_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_ready_i,
    input logic              busy_o,
    input logic              acc_valid_o,
    input logic [ADDR_W-1:0] acc_addr_o,
    input logic [IDX_W-1:0]  acc_reg_o,
    input logic              acc_load_o,
    input logic              done_o
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!acc_valid_o && !done_o));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && !mem_ready_i) |=>
            (acc_valid_o && $stable(acc_addr_o) && $stable(acc_reg_o)));

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && mem_ready_i) |=>
            (!acc_valid_o || ((acc_addr_o == $past(acc_addr_o) + ADDR_W'(4))
                              && (acc_reg_o > $past(acc_reg_o)))));

    p_dir_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && mem_ready_i) |=> (!acc_valid_o || $stable(acc_load_o)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && acc_valid_o));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && !mem_ready_i && start_i) |=> acc_valid_o);
endmodule

bind mrt_seq mrt_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mrt_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .acc_valid_o (acc_valid_o),
    .acc_addr_o  (acc_addr_o),
    .acc_reg_o   (acc_reg_o),
    .acc_load_o  (acc_load_o),
    .done_o      (done_o)
);

// File: tb/mrt_seq_bench.sv
module mrt_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] reg_list_i = '0;
    logic        pre_i = 1'b0, up_i = 1'b0, load_i = 1'b0;
    logic        mem_ready_i = 1'b1;
    logic        busy_o, acc_valid_o, acc_load_o, done_o;
    logic [31:0] acc_addr_o, wb_addr_o;
    logic [3:0]  acc_reg_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mrt_seq u_mrt_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .reg_list_i(reg_list_i), .pre_i(pre_i), .up_i(up_i), .load_i(load_i),
        .mem_ready_i(mem_ready_i), .busy_o(busy_o), .acc_valid_o(acc_valid_o),
        .acc_addr_o(acc_addr_o), .acc_reg_o(acc_reg_o), .acc_load_o(acc_load_o),
        .done_o(done_o), .wb_addr_o(wb_addr_o)
    );

    // {base, list, pre, up, load, stall, poke}
    localparam int NV = 8;
    localparam logic [52:0] VEC [NV] = '{
        {32'h0000_1000, 16'h00F1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {32'h0000_2000, 16'h8003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h0000_3000, 16'h0A50, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'h0000_4000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0000_5000, 16'h8001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h0000_6000, 16'h0110, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0000_0008, 16'h0007, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {32'hFFFF_FFF8, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nth_bit(input logic [15:0] l, input int k);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic run_xfer(input logic [31:0] b, input logic [15:0] l, input logic p,
                            input logic u, input logic ld, input logic stall,
                            input logic poke);
        int n = $countones(l);
        logic [31:0] low;
        int k = 0;
        int cyc = 0;
        bit last_taken = 0;
        bit held = 0;
        logic [31:0] prev_addr = '0;
        logic [3:0]  prev_reg = '0;
        // lowest address from the per-mode rules R2..R5
        if (u) low = p ? b + 32'd4 : b;
        else   low = (p ? b - 32'd4 : b) - 32'(4 * (n - 1));
        @(negedge clk);
        base_i = b; reg_list_i = l; pre_i = p; up_i = u; load_i = ld;
        start_i = 1'b1; mem_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (poke && cyc == 0) begin
                start_i = 1'b1; base_i = 32'hDEAD_0000; reg_list_i = 16'hFFFF;
                up_i = ~u; load_i = ~ld;
            end else begin
                start_i = 1'b0;
            end
            mem_ready_i = stall ? cyc[0] : 1'b1;
            #1;
            if (held)
                check(acc_valid_o && acc_addr_o == prev_addr && acc_reg_o == prev_reg,
                      "R8 hold", acc_addr_o, prev_addr);
            held = 0;
            if (last_taken) begin
                check(done_o && !acc_valid_o, "R9 done timing", {31'd0, done_o}, 32'd1);
                check(wb_addr_o == (u ? b + 32'(4 * n) : b - 32'(4 * n)), "R11 wb",
                      wb_addr_o, u ? b + 32'(4 * n) : b - 32'(4 * n));
                break;
            end
            if (done_o) begin
                check(0, "R9 early done", 32'(k), 32'(n));
                break;
            end
            if (acc_valid_o) begin
                if (mem_ready_i) begin
                    check(acc_addr_o == low + 32'(4 * k), "R2-5 addr", acc_addr_o,
                          low + 32'(4 * k));
                    check(32'(acc_reg_o) == 32'(nth_bit(l, k)), "R6 order",
                          32'(acc_reg_o), 32'(nth_bit(l, k)));
                    check(acc_load_o == ld, "R7 dir", {31'd0, acc_load_o}, {31'd0, ld});
                    k++;
                    if (k == n) last_taken = 1;
                end else begin
                    held = 1; prev_addr = acc_addr_o; prev_reg = acc_reg_o;
                end
            end
            cyc++;
            if (cyc > 200) begin
                check(0, "R9 hang", 32'(k), 32'(n));
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R9 one-cycle done", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !acc_valid_o && !done_o, "R1 reset",
              {29'd0, busy_o, acc_valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !acc_valid_o && !done_o, "R1 after release",
              {29'd0, busy_o, acc_valid_o, done_o}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            // modes: R2 R3 R4 R5, stall R8, wrap, poke R12
            run_xfer(VEC[v][52:21], VEC[v][20:5], VEC[v][4], VEC[v][3], VEC[v][2],
                     VEC[v][1], VEC[v][0]);
        end

        // R10: empty list
        @(negedge clk);
        base_i = 32'h0000_7000; reg_list_i = 16'h0000; pre_i = 1'b1; up_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(done_o && !acc_valid_o, "R10 empty done", {31'd0, done_o}, 32'd1);
        check(wb_addr_o == 32'h0000_7000, "R11 empty wb", wb_addr_o, 32'h0000_7000);
        @(negedge clk);
        check(!done_o && !busy_o, "R10 empty idle", {31'd0, done_o}, 32'd0);

        // corner: single top register, decrement-after (R4)
        run_xfer(32'h0000_0100, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // corner: single register 0, increment-before (R3)
        run_xfer(32'h0000_0200, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule